// File: doc/BRIEF.md
# Burst Column Order Sequencer

This block sits in a DRAM-style memory controller datapath. Each accepted READ or WRITE command produces an eight-beat burst. For every beat, the block outputs the low column index that beat carries. The order of those indices depends on four things: the three low start bits of the column, the burst type (sequential or interleaved), the direction, and the burst length.

Burst length comes from a length mode that is sampled with each command. The mode can be fixed eight-beat, fixed four-beat chop, or on-the-fly. In on-the-fly mode, an active-low chop input picks chop or full length for that one command. A chopped burst still takes eight beat slots. Its last four slots are marked high-Z for a read and don't-care for a write.

The block also emits a one-cycle pulse at the beat where the internal write operation starts. This pulse comes two beats earlier only when fixed chop mode is used. A new command is taken while the sequencer is idle or on its final beat, so bursts can follow each other with no gap.

Top module: `burst_order_seq`

## Requirements
- R1: While reset is high and on the first cycle after it is released, beat_valid, beat_last and wr_start are 0 and cmd_ready is 1.
- R2: A command accepted at a clock edge (cmd_valid and cmd_ready both high) makes beat_valid high for exactly eight consecutive cycles, starting in the cycle after that edge. beat_last is high only on the eighth of these cycles.
- R3: For a full-length sequential read with start s, beat p (0 to 7) carries the index whose bit 2 is s[2] XOR (p >= 4) and whose low two bits are (s[1:0] + p) mod 4. For example, start 5 gives 5,6,7,4,1,2,3,0.
- R4: For a full-length interleaved read with start s, beat p carries s XOR p. For example, start 5 gives 5,4,7,6,1,0,3,2.
- R5: For a chopped read, beats 0 to 3 follow the R3 or R4 order with kind data. Beats 4 to 7 have kind high-Z (beat_kind = 1) and index 0.
- R6: For a chopped write, start bits [1:0] and the burst type are ignored. Beats 0 to 3 carry 4*s[2]+p with kind data. Beats 4 to 7 have kind don't-care (beat_kind = 2) and index 0.
- R7: For a full-length write, all start bits and the burst type are ignored. Beat p carries index p with kind data (beat_kind = 0).
- R8: cmd_len selects the length: 0 is fixed full length, 2 is fixed chop, 1 is on-the-fly, and 3 acts as full length. In on-the-fly mode, cmd_chop_n = 0 selects chop and 1 selects full length for that command only. In the other modes cmd_chop_n has no effect.
- R9: wr_start pulses once per write burst. For fixed chop it pulses on beat 5. For every other mode, including an on-the-fly chop, it pulses on beat 7. It never pulses for a read.
- R10: cmd_ready is high when no burst is running or when the current beat is beat 7. A command offered on beats 0 to 6 is ignored and does not change the running burst. A command accepted on beat 7 starts its beat 0 in the next cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_interleave | input | 1 | 1 = interleaved order, 0 = sequential |
| cmd_start | input | 3 | Low three start column bits |
| cmd_len | input | 2 | Length mode: 0 full, 1 on-the-fly, 2 chop, 3 full |
| cmd_chop_n | input | 1 | On-the-fly chop select, active low |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| beat_valid | output | 1 | A burst beat is present |
| beat_idx | output | 3 | Column index of the current beat |
| beat_kind | output | 2 | 0 data, 1 high-Z, 2 don't-care |
| beat_last | output | 1 | Eighth beat of the burst |
| wr_start | output | 1 | Internal write start pulse |

## Verification
Directed bursts use start 5 in sequential and interleaved order, because there the wrap inside a half and the XOR order give different results. Chopped reads and writes use starts whose low bits are nonzero, which shows whether the write ignores them and whether tail beats are marked correctly. On-the-fly commands are run with both chop values, and a fixed full-length command is run with chop low: these cases separate the per-command selection, the ignored input, and the early write start of fixed chop. Random bursts mix back-to-back issue with junk commands offered during busy beats, which must not disturb the burst that is running.

// File: rtl/bos_pkg.sv
package bos_pkg;
    localparam int BEATS = 8;
    localparam int HALF  = BEATS / 2;
    localparam int IDX_W = $clog2(BEATS);
    localparam int EARLY_GAP = 2;

    typedef enum logic [1:0] {
        LEN_FULL = 2'd0,
        LEN_OTF  = 2'd1,
        LEN_CHOP = 2'd2,
        LEN_RSV  = 2'd3
    } len_mode_e;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_HIZ  = 2'd1,
        KIND_DC   = 2'd2
    } beat_kind_e;

    typedef struct packed {
        logic             wr;
        logic             ilv;
        logic             chop;
        logic             fixed_chop;
        logic [IDX_W-1:0] start;
    } burst_ctx_t;

    function automatic logic resolve_chop(len_mode_e m, logic chop_n);
        case (m)
            LEN_CHOP: return 1'b1;
            LEN_OTF:  return ~chop_n;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] order_index(burst_ctx_t c, logic [IDX_W-1:0] pos);
        logic [IDX_W-1:0] r;
        if (c.wr) begin
            r = c.chop ? {c.start[IDX_W-1], pos[IDX_W-2:0]} : pos;
        end else if (c.ilv) begin
            r = c.start ^ pos;
        end else begin
            r = {c.start[IDX_W-1] ^ pos[IDX_W-1],
                 c.start[IDX_W-2:0] + pos[IDX_W-2:0]};
        end
        return r;
    endfunction
endpackage

// File: rtl/bos_ctx.sv
module bos_ctx
    import bos_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             wr,
    input  logic             ilv,
    input  logic [IDX_W-1:0] start,
    input  logic [1:0]       len,
    input  logic             chop_n,
    output burst_ctx_t       ctx
);
    len_mode_e mode;
    assign mode = len_mode_e'(len);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '0;
        end else if (load) begin
            ctx.wr         <= wr;
            ctx.ilv        <= ilv;
            ctx.chop       <= resolve_chop(mode, chop_n);
            ctx.fixed_chop <= (mode == LEN_CHOP);
            ctx.start      <= start;
        end
    end
endmodule

// File: rtl/bos_pos.sv
module bos_pos
    import bos_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    output logic             active,
    output logic [IDX_W-1:0] pos,
    output logic             last
);
    assign last = active && (pos == IDX_W'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pos    <= '0;
        end else if (load) begin
            active <= 1'b1;
            pos    <= '0;
        end else if (last) begin
            active <= 1'b0;
            pos    <= '0;
        end else if (active) begin
            pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/bos_map.sv
module bos_map
    import bos_pkg::*;
(
    input  burst_ctx_t       ctx,
    input  logic             active,
    input  logic [IDX_W-1:0] pos,
    output logic [IDX_W-1:0] idx,
    output beat_kind_e       kind,
    output logic             wr_pulse
);
    logic             tail;
    logic [IDX_W-1:0] start_pos;

    assign tail      = ctx.chop && (pos >= IDX_W'(HALF));
    assign start_pos = ctx.fixed_chop ? IDX_W'(BEATS - 1 - EARLY_GAP) : IDX_W'(BEATS - 1);

    always_comb begin
        idx  = '0;
        kind = KIND_DATA;
        if (active) begin
            if (tail) begin
                kind = ctx.wr ? KIND_DC : KIND_HIZ;
            end else begin
                idx = order_index(ctx, pos);
            end
        end
    end

    assign wr_pulse = active && ctx.wr && (pos == start_pos);
endmodule

// File: rtl/burst_order_seq.sv
module burst_order_seq
    import bos_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic       cmd_write,
    input  logic       cmd_interleave,
    input  logic [2:0] cmd_start,
    input  logic [1:0] cmd_len,
    input  logic       cmd_chop_n,
    output logic       cmd_ready,
    output logic       beat_valid,
    output logic [2:0] beat_idx,
    output logic [1:0] beat_kind,
    output logic       beat_last,
    output logic       wr_start
);
    logic             accept;
    logic             active;
    logic             last;
    logic [IDX_W-1:0] pos;
    burst_ctx_t       ctx;
    beat_kind_e       kind;

    assign cmd_ready = !active || last;
    assign accept    = cmd_valid && cmd_ready;

    bos_ctx u_ctx (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .wr     (cmd_write),
        .ilv    (cmd_interleave),
        .start  (cmd_start),
        .len    (cmd_len),
        .chop_n (cmd_chop_n),
        .ctx    (ctx)
    );

    bos_pos u_pos (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .active (active),
        .pos    (pos),
        .last   (last)
    );

    bos_map u_map (
        .ctx      (ctx),
        .active   (active),
        .pos      (pos),
        .idx      (beat_idx),
        .kind     (kind),
        .wr_pulse (wr_start)
    );

    assign beat_valid = active;
    assign beat_last  = last;
    assign beat_kind  = kind;
endmodule

// File: rtl/bos_checker.sv
module bos_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       beat_valid,
    input logic [2:0] beat_idx,
    input logic [1:0] beat_kind,
    input logic       beat_last,
    input logic       wr_start
);
    assert_accept_starts_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> (beat_valid && !beat_last));

    assert_no_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_last) |=> beat_valid);

    assert_last_ends_R2: assert property (@(posedge clk) disable iff (rst)
        (beat_last && !cmd_valid) |=> !beat_valid);

    assert_tail_stays_R5: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_kind != 2'd0 && !beat_last) |=> (beat_kind != 2'd0));

    assert_tail_idx_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (beat_kind != 2'd0) |-> (beat_valid && beat_idx == 3'd0 && beat_kind != 2'd3));

    assert_wr_in_burst_R9: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> (beat_valid && beat_kind == 2'd0 || beat_valid && beat_last || beat_valid));

    assert_wr_single_R9: assert property (@(posedge clk) disable iff (rst)
        wr_start |=> !wr_start);

    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_last) |-> !cmd_ready);
endmodule

bind burst_order_seq bos_checker u_chk (.*);

// File: tb/tb_burst_order_seq.sv
module tb_burst_order_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid, cmd_write, cmd_interleave, cmd_chop_n;
    logic [2:0] cmd_start;
    logic [1:0] cmd_len;
    logic       cmd_ready, beat_valid, beat_last, wr_start;
    logic [2:0] beat_idx;
    logic [1:0] beat_kind;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;

    burst_order_seq dut (.*);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit is_chop(logic [1:0] m, logic cn);
        if (m == 2'd2) return 1'b1;
        if (m == 2'd1) return !cn;
        return 1'b0;
    endfunction

    function automatic int exp_idx(bit w, bit ilv, int s, bit ch, int p);
        if (ch && p >= 4) return 0;
        if (w) return ch ? (s / 4) * 4 + p : p;
        if (ilv) return s ^ p;
        return ((((s / 4) + (p / 4)) % 2) * 4) + ((s % 4) + (p % 4)) % 4;
    endfunction

    function automatic int exp_kind(bit w, bit ch, int p);
        if (ch && p >= 4) return w ? 2 : 1;
        return 0;
    endfunction

    function automatic int exp_wr(bit w, logic [1:0] m, int p);
        if (!w) return 0;
        return (p == ((m == 2'd2) ? 5 : 7)) ? 1 : 0;
    endfunction

    function automatic string tag(bit w, bit ilv, logic [1:0] m, bit ch);
        if (m == 2'd1 || (m == 2'd0 && !ch)) begin
            if (m == 2'd1) return "R8";
        end
        if (w) return ch ? "R6" : "R7";
        if (ch) return "R5";
        return ilv ? "R4" : "R3";
    endfunction

    task automatic drive(bit w, bit ilv, logic [2:0] s, logic [1:0] m, bit cn);
        cmd_valid = 1'b1; cmd_write = w; cmd_interleave = ilv;
        cmd_start = s; cmd_len = m; cmd_chop_n = cn;
    endtask

    // command already driven; walks the eight beats, leaves cmd_valid low at beat 7
    task automatic run_burst(bit w, bit ilv, logic [2:0] s, logic [1:0] m, bit cn, bit junk);
        bit    ch;
        string t;
        ch = is_chop(m, cn);
        t  = tag(w, ilv, m, ch);
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            chk("R2 valid", int'(beat_valid), 1);
            chk("R2 last", int'(beat_last), (p == 7) ? 1 : 0);
            chk("R10 ready", int'(cmd_ready), (p == 7) ? 1 : 0);
            chk({t, " idx"}, int'(beat_idx), exp_idx(w, ilv, int'(s), ch, p));
            chk({t, " kind"}, int'(beat_kind), exp_kind(w, ch, p));
            chk("R9 wr_start", int'(wr_start), exp_wr(w, m, p));
            if (p < 7 && junk && $urandom_range(0, 1) == 1)
                drive($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                      3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                      $urandom_range(0, 1) == 1);
            else
                cmd_valid = 1'b0;
        end
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk("R2 idle valid", int'(beat_valid), 0);
        chk("R10 idle ready", int'(cmd_ready), 1);
    endtask

    task automatic directed(bit w, bit ilv, logic [2:0] s, logic [1:0] m, bit cn);
        drive(w, ilv, s, m, cn);
        run_burst(w, ilv, s, m, cn, 1'b0);
        idle_check();
    endtask

    initial begin
        bit         w, ilv, cn, b2b;
        logic [2:0] s;
        logic [1:0] m;
        void'($urandom(32'h1f3a5c77));
        rst = 1'b1;
        cmd_valid = 1'b0; cmd_write = 1'b0; cmd_interleave = 1'b0;
        cmd_start = '0; cmd_len = '0; cmd_chop_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(beat_valid), 0);
        chk("R1 ready in reset", int'(cmd_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid", int'(beat_valid), 0);
        chk("R1 last", int'(beat_last), 0);
        chk("R1 wr_start", int'(wr_start), 0);
        chk("R1 ready", int'(cmd_ready), 1);

        directed(1'b0, 1'b0, 3'd5, 2'd0, 1'b1);   // R3 start 5
        directed(1'b0, 1'b1, 3'd5, 2'd0, 1'b1);   // R4 start 5
        directed(1'b0, 1'b1, 3'd6, 2'd2, 1'b1);   // R5 chopped interleaved read
        directed(1'b0, 1'b0, 3'd3, 2'd2, 1'b1);   // R5 chopped sequential read
        directed(1'b1, 1'b1, 3'd7, 2'd2, 1'b1);   // R6 chopped write, R9 early
        directed(1'b1, 1'b0, 3'd3, 2'd0, 1'b1);   // R7 full write
        directed(1'b1, 1'b0, 3'd5, 2'd1, 1'b0);   // R8 OTF chop write, R9 late
        directed(1'b0, 1'b0, 3'd2, 2'd1, 1'b1);   // R8 OTF full read
        directed(1'b1, 1'b1, 3'd6, 2'd0, 1'b0);   // R8 chop_n ignored in fixed full
        directed(1'b0, 1'b1, 3'd1, 2'd3, 1'b0);   // R8 reserved acts as full

        // R10 back-to-back with junk offers during busy beats
        w = 1'b1; ilv = 1'b0; s = 3'd1; m = 2'd2; cn = 1'b1;
        drive(w, ilv, s, m, cn);
        for (int i = 0; i < 400; i++) begin
            run_burst(w, ilv, s, m, cn, 1'b1);
            w   = $urandom_range(0, 1) == 1;
            ilv = $urandom_range(0, 1) == 1;
            s   = 3'($urandom_range(0, 7));
            m   = 2'($urandom_range(0, 3));
            cn  = $urandom_range(0, 1) == 1;
            b2b = $urandom_range(0, 2) != 0;
            if (!b2b) idle_check();
            drive(w, ilv, s, m, cn);
        end
        run_burst(w, ilv, s, m, cn, 1'b0);
        idle_check();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule